// File: doc/BRIEF.md
# SPI Serial Memory Command Controller

This block is the slave side of an SPI link in front of a small byte-wide memory, held on chip as a register array. A host lowers chip select, shifts in an 8-bit command, most significant bit first, and then any address and data bytes the command needs. The block answers in SPI mode 0 and in mode 3. It can stream memory or the status register back to the host, take up to a page of write data, and set or clear its write-enable latch.

Memory and status writes are held back until chip select rises on a byte boundary. At that point a self-timed write cycle of a fixed number of system clocks starts. While that cycle runs, the busy flag is set and only status reads are served. Three things gate every write: the write-enable latch, a 2-bit block-protect code that closes the upper quarter, the upper half or the whole array, and a write-protect pin that can lock the status register.

All serial inputs are resynchronised into the system clock. Edges of the serial clock and of chip select are found after that synchronisation.

Top module: `spi_nvm_ctrl`

## Requirements
- R1: After reset, `so_oe` is 0, every memory byte reads 0x00 and the status register reads 0x00.
- R2: Input bits are taken on rising serial clock edges and output bits change on falling edges. Mode 0 (clock idles low) and mode 3 (clock idles high) give the same results.
- R3: `so_oe` is 0 whenever chip select is high and no read command is active. An opcode other than 0x06, 0x04, 0x05, 0x01, 0x03 or 0x02 keeps `so_oe` at 0 for the rest of that frame, and the next frame is decoded normally.
- R4: Opcode 0x05 returns the status byte, repeated for as long as clocks continue. Its layout is bit 7 = protect-pin enable, bits 6..4 = 0, bits 3..2 = block-protect code, bit 1 = write-enable latch, bit 0 = busy.
- R5: Opcode 0x06 sets the latch and opcode 0x04 clears it. Either takes effect only when chip select rises after the command.
- R6: Opcode 0x02 (address, then data) with the latch clear changes no memory and starts no write cycle.
- R7: Opcode 0x03 followed by an address streams bytes from that address upward. After the top address it continues at address 0.
- R8: Write data fills successive addresses inside one 16-byte page. Past the last byte of the page it continues at the page start.
- R9: A write cycle starts only when chip select rises after a whole number of data bytes, and busy then reads 1 for the cycle length. A rise in the middle of a byte discards the write and leaves the latch set.
- R10: While busy, every opcode other than 0x05 is ignored. A read command issued then keeps `so_oe` at 0.
- R11: The latch reads 0 after any memory or status write cycle finishes.
- R12: Opcode 0x01 followed by one data byte changes only bits 7, 3 and 2 of the status register, at the end of its write cycle.
- R13: Block-protect code 01 refuses writes to addresses 0xC0..0xFF, code 10 refuses 0x80..0xFF and code 11 refuses all addresses. A refused write starts no cycle and leaves the latch set.
- R14: With `wp_n` low and bit 7 of the status set, a status write is refused. `wp_n` falling while chip select is still low cancels that frame's status write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for `so` (0 means high impedance) |

## Verification
A wrong frame state shows up on the first read byte that follows it. A misdecoded or mis-sequenced command either drives `so_oe` when it should not, or returns a byte with some bits wrong. A stray or missing write commit shows up in the busy bit, which is polled within one status frame after chip select rises. It also shows up later as a wrong byte in a read-back. Latch and protection errors appear in the status byte at the next status read, because refused writes leave a set latch with busy clear.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    FS_IDLE, FS_OP, FS_ADDR, FS_RDAT, FS_RSR, FS_WDAT, FS_WSR, FS_SKIP
  } fstate_t;

  typedef enum logic [1:0] { LK_NONE, LK_SET, LK_CLR } latch_op_t;

  // top two address bits against the block-protect code
  function automatic logic in_protected(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] sr_pack(input logic wpen, input logic [1:0] bp,
                                         input logic wel, input logic busy);
    return {wpen, 3'b000, bp, wel, busy};
  endfunction
endpackage

// File: rtl/spi_nvm_sync.sv
module spi_nvm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic cs_low,
  output logic si_s,
  output logic wp_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise
);
  // lane order: {wp_n, si, sck, cs_n}
  localparam logic [3:0] RST_VAL = 4'b1001;
  logic [STAGES-1:0][3:0] pipe;
  logic [3:0] cur;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe  <= {STAGES{RST_VAL}};
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      pipe  <= {pipe[STAGES-2:0], {wp_n, si, sck, cs_n}};
      sck_d <= cur[1];
      cs_d  <= cur[0];
    end
  end

  assign cur      = pipe[STAGES-1];
  assign cs_low   = ~cur[0];
  assign si_s     = cur[2];
  assign wp_s     = cur[3];
  assign sck_rise = cur[1] & ~sck_d;
  assign sck_fall = ~cur[1] & sck_d;
  assign cs_fall  = ~cur[0] & cs_d;
  assign cs_rise  = cur[0] & ~cs_d;

  AST_CS_EDGES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !cs_fall); // R3
endmodule

// File: rtl/spi_nvm_wtimer.sv
module spi_nvm_wtimer #(
  parameter int CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CW'(CYCLES);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign busy = cnt != '0;
  assign done = cnt == CW'(1);

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9
endmodule

// File: rtl/spi_nvm_pagebuf.sv
module spi_nvm_pagebuf #(
  parameter int PAGE_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [PAGE_W-1:0]               start_off,
  input  logic                            push,
  input  logic [7:0]                      din,
  output logic [(1<<PAGE_W)-1:0][7:0]     data,
  output logic [(1<<PAGE_W)-1:0]          mask,
  output logic                            any
);
  logic [PAGE_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      data <= '0;
      mask <= '0;
      any  <= 1'b0;
    end else if (load) begin
      ptr  <= start_off;
      mask <= '0;
      any  <= 1'b0;
    end else if (push) begin
      data[ptr] <= din;
      mask[ptr] <= 1'b1;
      ptr       <= ptr + PAGE_W'(1);   // wraps inside the page
      any       <= 1'b1;
    end
  end

  AST_PUSH_MARKS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !load) |=> (any && mask != '0)); // R8
endmodule

// File: rtl/spi_nvm_array.sv
module spi_nvm_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [7:0]                    rd_data,
  input  logic                          commit,
  input  logic [ADDR_W-PAGE_W-1:0]      page_base,
  input  logic [(1<<PAGE_W)-1:0][7:0]   wdata,
  input  logic [(1<<PAGE_W)-1:0]        wmask
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] slot_addr [PAGE];

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    assign slot_addr[g] = {page_base, PAGE_W'(g)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (commit) begin
      for (int p = 0; p < PAGE; p++)
        if (wmask[p]) mem[slot_addr[p]] <= wdata[p];
    end
  end

  assign rd_data = mem[rd_addr];

  AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wmask != '0)); // R9
endmodule

// File: rtl/spi_nvm_ctrl.sv
module spi_nvm_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int WR_CYCLES   = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  import spi_nvm_pkg::*;

  localparam int PAGE       = 1 << PAGE_W;
  localparam int PB_W       = ADDR_W - PAGE_W;
  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int AB_W       = 8 * ADDR_BYTES;
  localparam int AC_W       = $clog2(ADDR_BYTES + 1);

  // synchronised inputs and edge events
  logic cs_low, si_s, wp_s, sck_rise, sck_fall, cs_fall, cs_rise;

  spi_nvm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .cs_n, .sck, .si, .wp_n,
    .cs_low, .si_s, .wp_s, .sck_rise, .sck_fall, .cs_fall, .cs_rise
  );

  fstate_t           st;
  logic [2:0]        bitc;
  logic [6:0]        rx_sh;
  logic [7:0]        tx_sh;
  logic              so_q;
  logic [AB_W-1:0]   addr_acc;
  logic [AC_W-1:0]   abyte;
  logic              is_rd;
  logic [ADDR_W-1:0] rd_ptr;
  logic [PB_W-1:0]   page_base;
  latch_op_t         pend_lk;
  logic [7:0]        sr_new;
  logic              sr_have, sr_kill;

  // status register
  logic       wel, wpen;
  logic [1:0] bp;
  logic       wk_sr;

  // named internal events
  logic              bit_ev, byte_done, last_abyte;
  logic [7:0]        rx_byte;
  logic [AB_W-1:0]   addr_nx;
  logic [ADDR_W-1:0] addr_word, rd_addr;
  logic [7:0]        rd_data, sr_val;
  logic              pb_load, pb_push, pb_any;
  logic [PAGE-1:0][7:0] pb_data;
  logic [PAGE-1:0]   pb_mask;
  logic              mem_go, sr_go, wr_start, wr_done, busy, mem_commit;
  logic              pin_lock;

  assign bit_ev     = sck_rise && !cs_fall && !cs_rise && st != FS_IDLE;
  assign byte_done  = bitc == 3'd7;
  assign rx_byte    = {rx_sh, si_s};
  assign addr_nx    = AB_W'({addr_acc, rx_byte});
  assign addr_word  = addr_nx[ADDR_W-1:0];
  assign last_abyte = abyte == AC_W'(ADDR_BYTES - 1);
  assign rd_addr    = (st == FS_ADDR) ? addr_word : rd_ptr;
  assign sr_val     = sr_pack(wpen, bp, wel, busy);
  assign pin_lock   = wpen && !wp_s;

  assign pb_load = bit_ev && byte_done && st == FS_ADDR && last_abyte && !is_rd;
  assign pb_push = bit_ev && byte_done && st == FS_WDAT;

  // frame engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      bitc      <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      so_q      <= 1'b0;
      addr_acc  <= '0;
      abyte     <= '0;
      is_rd     <= 1'b0;
      rd_ptr    <= '0;
      page_base <= '0;
      pend_lk   <= LK_NONE;
      sr_new    <= '0;
      sr_have   <= 1'b0;
      sr_kill   <= 1'b0;
    end else begin
      if (cs_fall) begin
        st      <= FS_OP;
        bitc    <= '0;
        abyte   <= '0;
        pend_lk <= LK_NONE;
        sr_have <= 1'b0;
        sr_kill <= 1'b0;
      end else if (cs_rise) begin
        st <= FS_IDLE;
      end else if (bit_ev) begin
        rx_sh <= rx_byte[6:0];
        bitc  <= bitc + 3'd1;
        if (byte_done) begin
          case (st)
            FS_OP: begin
              if (busy && rx_byte != OP_RDSR) st <= FS_SKIP;
              else begin
                case (rx_byte)
                  OP_WREN:  begin pend_lk <= LK_SET; st <= FS_SKIP; end
                  OP_WRDI:  begin pend_lk <= LK_CLR; st <= FS_SKIP; end
                  OP_RDSR:  begin tx_sh <= sr_val; st <= FS_RSR; end
                  OP_WRSR:  st <= wel ? FS_WSR : FS_SKIP;
                  OP_READ:  begin is_rd <= 1'b1; st <= FS_ADDR; end
                  OP_WRITE: begin is_rd <= 1'b0; st <= wel ? FS_ADDR : FS_SKIP; end
                  default:  st <= FS_SKIP;
                endcase
              end
            end
            FS_ADDR: begin
              addr_acc <= addr_nx;
              abyte    <= abyte + AC_W'(1);
              if (last_abyte) begin
                if (is_rd) begin
                  tx_sh  <= rd_data;
                  rd_ptr <= addr_word + ADDR_W'(1);
                  st     <= FS_RDAT;
                end else begin
                  page_base <= addr_word[ADDR_W-1:PAGE_W];
                  st        <= FS_WDAT;
                end
              end
            end
            FS_RDAT: begin
              tx_sh  <= rd_data;
              rd_ptr <= rd_ptr + ADDR_W'(1);
            end
            FS_RSR:  tx_sh <= sr_val;
            FS_WSR:  begin sr_new <= rx_byte; sr_have <= 1'b1; end
            default: ;
          endcase
        end
      end
      if (sck_fall && (st == FS_RDAT || st == FS_RSR)) begin
        so_q  <= tx_sh[7];
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
      if (st == FS_WSR && pin_lock) sr_kill <= 1'b1;
    end
  end

  assign so    = so_q;
  assign so_oe = (st == FS_RDAT) || (st == FS_RSR);

  // commit decisions at chip-select rise
  assign mem_go   = st == FS_WDAT && bitc == 3'd0 && pb_any && !busy && wel &&
                    !in_protected(bp, page_base[PB_W-1 -: 2]);
  assign sr_go    = st == FS_WSR && bitc == 3'd0 && sr_have && !sr_kill &&
                    !pin_lock && !busy && wel;
  assign wr_start = cs_rise && (mem_go || sr_go);

  spi_nvm_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk, .rst_n, .start(wr_start), .busy, .done(wr_done)
  );

  assign mem_commit = wr_done && !wk_sr;

  spi_nvm_pagebuf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk, .rst_n, .load(pb_load), .start_off(addr_word[PAGE_W-1:0]),
    .push(pb_push), .din(rx_byte), .data(pb_data), .mask(pb_mask), .any(pb_any)
  );

  spi_nvm_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk, .rst_n, .rd_addr, .rd_data, .commit(mem_commit),
    .page_base, .wdata(pb_data), .wmask(pb_mask)
  );

  // status register and latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel   <= 1'b0;
      wpen  <= 1'b0;
      bp    <= 2'b00;
      wk_sr <= 1'b0;
    end else begin
      if (wr_start) wk_sr <= sr_go;
      if (wr_done) begin
        wel <= 1'b0;
        if (wk_sr) begin
          wpen <= sr_new[7];
          bp   <= sr_new[3:2];
        end
      end else if (cs_rise && !busy) begin
        if (pend_lk == LK_SET)      wel <= 1'b1;
        else if (pend_lk == LK_CLR) wel <= 1'b0;
      end
    end
  end

  AST_SO_QUIET_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_low && !cs_rise) |-> !so_oe); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> !busy); // R10
  AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wel); // R11
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done |=> $stable({wpen, bp})); // R12
  AST_PROT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_commit |-> !in_protected(bp, page_base[PB_W-1 -: 2])); // R13
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> wel); // R6
endmodule

// File: tb/spi_nvm_ctrl_tb_top.sv
module spi_nvm_ctrl_tb_top;
  localparam int WCYC = 2000;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;

  always #2.5 clk = ~clk;

  spi_nvm_ctrl #(.ADDR_W(8), .PAGE_W(4), .WR_CYCLES(WCYC), .SYNC_STAGES(2)) dut_i (
    .clk, .rst_n, .cs_n, .sck, .si, .wp_n, .so, .so_oe
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] tx [0:7];
  logic [7:0] rx [0:7];
  bit oe_seen;
  int drop_at = -1;

  // scoreboard queues
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] e, input logic [7:0] a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    act_q.push_back(a);
  endtask

  // monitor: pops and compares
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        automatic logic [7:0] a = act_q.pop_front();
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: got %02h expected %02h", t, a, e);
        end
      end
    end
  end

  task automatic frame(input int nb, input int xb, input bit m3);
    sck = m3;
    tick(4);
    cs_n = 1'b0;
    tick(6);
    oe_seen = 1'b0;
    for (int b = 0; b < nb * 8 + xb; b++) begin
      sck = 1'b0;
      si = tx[b / 8][7 - b % 8];
      if (b == drop_at) wp_n = 1'b0;
      tick(HALF);
      rx[b / 8][7 - b % 8] = so;
      if (so_oe) oe_seen = 1'b1;
      sck = 1'b1;
      tick(HALF);
    end
    if (!m3) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic cmd1(input logic [7:0] op);
    tx[0] = op;
    frame(1, 0, 1'b0);
  endtask

  task automatic rdsr(input string tag, input logic [7:0] e);
    tx[0] = 8'h05; tx[1] = 8'h00; tx[2] = 8'h00;
    frame(3, 0, 1'b0);
    expect_byte(tag, e, rx[1]);
    expect_byte(tag, e, rx[2]);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    tx[0] = 8'h02; tx[1] = a; tx[2] = d;
    frame(3, 0, 1'b0);
  endtask

  task automatic rd1(input string tag, input logic [7:0] a, input logic [7:0] e);
    tx[0] = 8'h03; tx[1] = a; tx[2] = 8'h00;
    frame(3, 0, 1'b0);
    expect_byte(tag, e, rx[2]);
  endtask

  task automatic settle();
    tick(WCYC + 20);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // R1 reset state
    expect_byte("R1 so_oe after reset", 8'h00, {7'b0, so_oe});
    rdsr("R1 R4 status after reset", 8'h00);
    rd1("R1 memory after reset", 8'h37, 8'h00);

    // R6 write with latch clear
    wr1(8'h10, 8'hAA);
    rdsr("R6 no cycle without latch", 8'h00);
    rd1("R6 memory unchanged", 8'h10, 8'h00);

    // R5 latch set and clear
    cmd1(8'h06);
    rdsr("R5 latch set", 8'h02);
    cmd1(8'h04);
    rdsr("R5 latch cleared", 8'h00);

    // R8 page write in mode 3 with wrap, R9 busy
    cmd1(8'h06);
    tx[0] = 8'h02; tx[1] = 8'h1E; tx[2] = 8'h11; tx[3] = 8'h22; tx[4] = 8'h33; tx[5] = 8'h44;
    frame(6, 0, 1'b1);
    rdsr("R9 busy after write", 8'h03);
    tx[0] = 8'h03; tx[1] = 8'h10; tx[2] = 8'h00;
    frame(3, 0, 1'b0);
    expect_byte("R10 read ignored while busy", 8'h00, {7'b0, oe_seen});
    settle();
    rdsr("R11 latch clear after cycle", 8'h00);
    tx[0] = 8'h03; tx[1] = 8'h10; tx[2] = 8'h00; tx[3] = 8'h00; tx[4] = 8'h00;
    frame(5, 0, 1'b0);
    expect_byte("R8 wrapped byte 0x10", 8'h33, rx[2]);
    expect_byte("R8 wrapped byte 0x11", 8'h44, rx[3]);
    expect_byte("R7 next byte 0x12", 8'h00, rx[4]);
    tx[0] = 8'h03; tx[1] = 8'h1E; tx[2] = 8'h00; tx[3] = 8'h00;
    frame(4, 0, 1'b1);
    expect_byte("R2 mode3 read 0x1E", 8'h11, rx[2]);
    expect_byte("R2 mode3 read 0x1F", 8'h22, rx[3]);
    expect_byte("R3 so_oe low after read", 8'h00, {7'b0, so_oe});

    // R7 wrap at top address
    cmd1(8'h06);
    wr1(8'hFF, 8'h5A);
    settle();
    cmd1(8'h06);
    wr1(8'h00, 8'hC3);
    settle();
    tx[0] = 8'h03; tx[1] = 8'hFF; tx[2] = 8'h00; tx[3] = 8'h00;
    frame(4, 0, 1'b0);
    expect_byte("R7 top byte", 8'h5A, rx[2]);
    expect_byte("R7 wrapped to zero", 8'hC3, rx[3]);

    // R3 unknown opcode
    tx[0] = 8'h9C; tx[1] = 8'h03; tx[2] = 8'h10; tx[3] = 8'h00;
    frame(4, 0, 1'b0);
    expect_byte("R3 unknown opcode keeps so quiet", 8'h00, {7'b0, oe_seen});
    rdsr("R3 next frame decoded", 8'h00);

    // R9 partial byte discards write
    cmd1(8'h06);
    tx[0] = 8'h02; tx[1] = 8'h40; tx[2] = 8'hFF;
    frame(2, 5, 1'b0);
    rdsr("R9 partial byte no cycle", 8'h02);
    rd1("R9 partial byte memory", 8'h40, 8'h00);

    // R12 status write masks bits
    tx[0] = 8'h01; tx[1] = 8'hFF;
    frame(2, 0, 1'b0);
    settle();
    rdsr("R12 only bits 7,3,2 written", 8'h8C);

    // R13 full protection
    cmd1(8'h06);
    wr1(8'h00, 8'h77);
    rdsr("R13 refused write keeps latch", 8'h8E);
    rd1("R13 protected byte", 8'h00, 8'hC3);

    // R14 pin lock
    wp_n = 1'b0;
    tx[0] = 8'h01; tx[1] = 8'h00;
    frame(2, 0, 1'b0);
    wp_n = 1'b1;
    tick(4);
    rdsr("R14 pin blocks status write", 8'h8E);

    tx[0] = 8'h01; tx[1] = 8'h84;
    frame(2, 0, 1'b0);
    settle();
    rdsr("R12 status now quarter protect", 8'h84);

    // R13 quarter protection
    cmd1(8'h06);
    wr1(8'hC0, 8'h66);
    rdsr("R13 quarter refuses 0xC0", 8'h86);
    wr1(8'hBF, 8'h99);
    settle();
    rdsr("R11 latch cleared after write", 8'h84);
    rd1("R13 unprotected 0xBF written", 8'hBF, 8'h99);
    rd1("R13 protected 0xC0 unchanged", 8'hC0, 8'h00);

    // R14 pin drop mid-frame cancels
    cmd1(8'h06);
    drop_at = 12;
    tx[0] = 8'h01; tx[1] = 8'h00;
    frame(2, 0, 1'b0);
    drop_at = -1;
    wp_n = 1'b1;
    tick(4);
    settle();
    rdsr("R14 cancelled status write", 8'h86);
    tx[0] = 8'h01; tx[1] = 8'h00;
    frame(2, 0, 1'b0);
    settle();
    rdsr("R12 status write with pin high", 8'h00);

    tick(10);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule